// File: doc/BRIEF.md
# Dual DAC Double-Buffered Loader

This block sits between a host byte/word bus and two digital-to-analog converter channels. Each channel has a staging pair of byte registers (low and high) that the host fills. It also has an output latch that holds the code presented to the converter. A shared range register carries a 2-bit output-range code for each channel. The converters themselves lie outside the block. It produces the latched codes, a one-cycle update strobe per channel and the range codes.

A strap input picks the update policy. With the strap low, each channel updates on its own: writing the channel's high byte, or writing the whole word, moves the new staged value into that channel's latch. With the strap high, writes only fill the staging registers. A host read of any converter register then moves both staged values into both latches in the same cycle, so the two outputs change together. The parameter `DATA_W` selects the code width, 12 or 16 bits. At 12 bits the code is left-justified across the two bytes and the bottom nibble of the low byte is discarded.

Top module: `dac_pair_loader`

## Requirements
- R1: After reset both output codes are 0 and both update strobes are low. Both range codes are 2 (unipolar 5 V), where the range encoding is 0 = bipolar 5 V, 1 = bipolar 10 V, 2 = unipolar 5 V and 3 = unipolar 10 V.
- R2: A byte write to offset 0x04+2n stores `wdata[7:0]` as channel n's staged low byte, and a byte write to offset 0x05+2n stores it as the staged high byte (n = 0 or 1). A byte read at those offsets returns the staged byte in `rdata[7:0]`, with `rdata[15:8]` zero.
- R3: With `sim_mode` low, a high-byte write or a word write to channel n loads that channel's latch from the just-written staged value. The code and a high `upd[n]` appear in the cycle after the write edge, and the strobe lasts one cycle.
- R4: With `sim_mode` low, low-byte writes and all reads leave both latches unchanged and raise no strobe.
- R5: With `sim_mode` high, writes never change a latch. A read without a write at any offset 0x04 to 0x07 loads both latches from their staged values, with both strobes high together in the next cycle. Reads elsewhere do nothing.
- R6: With `DATA_W`=16 the code is {high, low}. With `DATA_W`=12 the code is {high, low[7:4]}, and low[3:0] is discarded, so it reads back as zero.
- R7: A word access (`host_word`=1) ignores address bit 0. A word write loads low from `wdata[7:0]` and high from `wdata[15:8]` together. A word read of a channel returns {high, low}.
- R8: A write to offset 0x0A (byte, or word with `wdata[7:0]`) sets the channel 0 range from bits 5:4 and the channel 1 range from bits 7:6. A read there returns those bits in place, with all other bits zero. A byte write to 0x0B, or a write to any offset outside 0x04–0x07 and 0x0A, changes nothing.
- R9: When `host_wr` and `host_rd` are both high, the write takes effect and the read causes no transfer.
- R10: A latch changes only in a cycle where its strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sim_mode | input | 1 | Strap: 0 = per-channel update, 1 = simultaneous update on read |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 16 | Write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_rdata | output | 16 | Read data (combinational) |
| dac0_code | output | DATA_W | Channel 0 latched code |
| dac1_code | output | DATA_W | Channel 1 latched code |
| upd | output | 2 | Per-channel one-cycle update strobes |
| rng0 | output | 2 | Channel 0 range code |
| rng1 | output | 2 | Channel 1 range code |

## Verification
The bench builds two copies of the block that share one bus: one with `DATA_W`=16 and one with `DATA_W`=12. Every random and directed cycle therefore checks the full-word code path and the left-justified path side by side, including low nibbles that the narrow copy must drop. Both straps are run after separate resets, so both update policies are covered with the same random address mix. That mix includes write-plus-read collisions and stray offsets such as 0x0B.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam logic [1:0] RNG_UNI5 = 2'd2;

  // Keep only the upper (width-8) bits of the low byte.
  function automatic logic [7:0] lo_mask(input int unsigned width);
    return 8'hFF << (16 - width);
  endfunction

  // Staged bytes to a right-aligned code of the given width.
  function automatic logic [15:0] bytes_to_code(input logic [7:0] hi,
                                                input logic [7:0] lo,
                                                input int unsigned width);
    return {hi, lo} >> (16 - width);
  endfunction
endpackage

// File: rtl/dac_host_decode.sv
module dac_host_decode (
  input  logic [3:0] addr,
  input  logic       word,
  input  logic       wr,
  input  logic       rd,
  input  logic       sim_mode,
  output logic [1:0] lo_we,
  output logic [1:0] hi_we,
  output logic       rng_we,
  output logic       xfer,
  output logic [1:0] load
);
  logic dac_hit;
  logic ch;

  always_comb begin
    dac_hit = (addr[3:2] == 2'b01);
    ch      = addr[1];
    lo_we   = '0;
    hi_we   = '0;
    if (wr && dac_hit) begin
      lo_we[ch] = word || !addr[0];
      hi_we[ch] = word ||  addr[0];
    end
    rng_we = wr && (addr[3:1] == 3'b101) && (word || !addr[0]);
    xfer   = sim_mode && rd && !wr && dac_hit;
    load   = xfer ? 2'b11 : (sim_mode ? 2'b00 : hi_we);
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [7:0]        lo_in,
  input  logic [7:0]        hi_in,
  input  logic              load,
  output logic [7:0]        stg_lo,
  output logic [7:0]        stg_hi,
  output logic [DATA_W-1:0] code,
  output logic              upd
);
  import dac_loader_pkg::*;

  logic [7:0]  lo_nxt;
  logic [7:0]  hi_nxt;
  logic [15:0] code_nxt;

  always_comb begin
    lo_nxt   = lo_we ? (lo_in & lo_mask(DATA_W)) : stg_lo;
    hi_nxt   = hi_we ? hi_in : stg_hi;
    code_nxt = bytes_to_code(hi_nxt, lo_nxt, DATA_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_lo <= '0;
      stg_hi <= '0;
      code   <= '0;
      upd    <= 1'b0;
    end else begin
      stg_lo <= lo_nxt;
      stg_hi <= hi_nxt;
      upd    <= load;
      if (load) code <= code_nxt[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/dac_range_reg.sv
module dac_range_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wbyte,
  output logic [1:0] rng0,
  output logic [1:0] rng1
);
  import dac_loader_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rng0 <= RNG_UNI5;
      rng1 <= RNG_UNI5;
    end else if (we) begin
      rng0 <= wbyte[5:4];
      rng1 <= wbyte[7:6];
    end
  end
endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sim_mode,
  input  logic [3:0]        host_addr,
  input  logic [15:0]       host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_word,
  output logic [15:0]       host_rdata,
  output logic [DATA_W-1:0] dac0_code,
  output logic [DATA_W-1:0] dac1_code,
  output logic [1:0]        upd,
  output logic [1:0]        rng0,
  output logic [1:0]        rng1
);
  localparam int unsigned NCH = 2;

  // Named internal events for the checker.
  logic [NCH-1:0] ev_lo_we;
  logic [NCH-1:0] ev_hi_load;
  logic [NCH-1:0] ev_load;
  logic           ev_rng_we;
  logic           ev_xfer;

  logic [7:0]        stg_lo [NCH];
  logic [7:0]        stg_hi [NCH];
  logic [DATA_W-1:0] code   [NCH];
  logic [7:0]        lo_src;
  logic [7:0]        hi_src;

  assign lo_src = host_wdata[7:0];
  assign hi_src = host_word ? host_wdata[15:8] : host_wdata[7:0];

  dac_host_decode u_dec (
    .addr     (host_addr),
    .word     (host_word),
    .wr       (host_wr),
    .rd       (host_rd),
    .sim_mode (sim_mode),
    .lo_we    (ev_lo_we),
    .hi_we    (ev_hi_load),
    .rng_we   (ev_rng_we),
    .xfer     (ev_xfer),
    .load     (ev_load)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dac_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .lo_we  (ev_lo_we[n]),
      .hi_we  (ev_hi_load[n]),
      .lo_in  (lo_src),
      .hi_in  (hi_src),
      .load   (ev_load[n]),
      .stg_lo (stg_lo[n]),
      .stg_hi (stg_hi[n]),
      .code   (code[n]),
      .upd    (upd[n])
    );
  end

  assign dac0_code = code[0];
  assign dac1_code = code[1];

  dac_range_reg u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_rng_we),
    .wbyte (host_wdata[7:0]),
    .rng0  (rng0),
    .rng1  (rng1)
  );

  always_comb begin
    host_rdata = '0;
    if (host_addr[3:2] == 2'b01) begin
      if (host_word)
        host_rdata = {stg_hi[host_addr[1]], stg_lo[host_addr[1]]};
      else if (host_addr[0])
        host_rdata = {8'h00, stg_hi[host_addr[1]]};
      else
        host_rdata = {8'h00, stg_lo[host_addr[1]]};
    end else if (host_addr[3:1] == 3'b101 && (host_word || !host_addr[0])) begin
      host_rdata = {8'h00, rng1, rng0, 4'h0};
    end
  end
endmodule

// File: rtl/dac_pair_loader_checker.sv
module dac_pair_loader_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sim_mode,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        upd,
  input logic [DATA_W-1:0] dac0_code,
  input logic [DATA_W-1:0] dac1_code,
  input logic [1:0]        ev_hi_load,
  input logic              ev_xfer
);
  assert_hold0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[0] |-> $stable(dac0_code));
  assert_hold1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd[1] |-> $stable(dac1_code));
  assert_sim_wr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sim_mode && host_wr |=> upd == 2'b00);
  assert_xfer_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |=> upd == 2'b11);
  assert_indiv_nowr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sim_mode && !host_wr |=> upd == 2'b00);
  assert_hi_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sim_mode && ev_hi_load[0] |=> upd == 2'b01);
  assert_hi_load1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sim_mode && ev_hi_load[1] |=> upd == 2'b10);
  assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_rd |-> !ev_xfer);
endmodule

bind dac_pair_loader dac_pair_loader_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sim_mode   (sim_mode),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .upd        (upd),
  .dac0_code  (dac0_code),
  .dac1_code  (dac1_code),
  .ev_hi_load (ev_hi_load),
  .ev_xfer    (ev_xfer)
);

// File: tb/dac_pair_loader_test.sv
module dac_pair_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sim_mode = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0, word = 1'b0;

  logic [15:0] rdata_a, rdata_b;
  logic [15:0] c0_a, c1_a;
  logic [11:0] c0_b, c1_b;
  logic [1:0]  upd_a, upd_b, r0_a, r1_a, r0_b, r1_b;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0]  m_lo [2];
  logic [7:0]  m_hi [2];
  logic [15:0] m_lat16 [2];
  logic [15:0] m_lat12 [2];
  logic [3:0]  m_rng;
  logic [1:0]  m_upd;

  always #2.5 clk = ~clk;

  dac_pair_loader #(.DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .sim_mode(sim_mode), .host_addr(addr),
    .host_wdata(wdata), .host_wr(wr), .host_rd(rd), .host_word(word),
    .host_rdata(rdata_a), .dac0_code(c0_a), .dac1_code(c1_a),
    .upd(upd_a), .rng0(r0_a), .rng1(r1_a));

  dac_pair_loader #(.DATA_W(12)) uut12 (
    .clk(clk), .rst_n(rst_n), .sim_mode(sim_mode), .host_addr(addr),
    .host_wdata(wdata), .host_wr(wr), .host_rd(rd), .host_word(word),
    .host_rdata(rdata_b), .dac0_code(c0_b), .dac1_code(c1_b),
    .upd(upd_b), .rng0(r0_b), .rng1(r1_b));

  function automatic logic [7:0] keep_lo(input logic [7:0] lo, input int w);
    return (w == 12) ? {lo[7:4], 4'h0} : lo;
  endfunction

  function automatic logic [15:0] exp_code(input logic [7:0] hi, input logic [7:0] lo,
                                           input int w);
    return (w == 12) ? {4'h0, hi, lo[7:4]} : {hi, lo};
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [3:0] a, input logic wd, input int w);
    int c;
    c = a[1];
    if (a >= 4'h4 && a <= 4'h7) begin
      if (wd) return {m_hi[c], keep_lo(m_lo[c], w)};
      if (a[0]) return {8'h00, m_hi[c]};
      return {8'h00, keep_lo(m_lo[c], w)};
    end
    if (a == 4'hA || (a == 4'hB && wd)) return {8'h00, m_rng, 4'h0};
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < 2; n++) begin
      m_lo[n] = '0; m_hi[n] = '0; m_lat16[n] = '0; m_lat12[n] = '0;
    end
    m_rng = 4'b1010;
    m_upd = '0;
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " code0 w16 R3 R5 R6 R10"}, c0_a, m_lat16[0]);
    check({tag, " code1 w16 R3 R5 R6 R10"}, c1_a, m_lat16[1]);
    check({tag, " code0 w12 R6"}, {4'h0, c0_b}, m_lat12[0]);
    check({tag, " code1 w12 R6"}, {4'h0, c1_b}, m_lat12[1]);
    check({tag, " upd w16 R3 R4 R5 R9"}, {14'h0, upd_a}, {14'h0, m_upd});
    check({tag, " upd w12 R3 R4 R5"}, {14'h0, upd_b}, {14'h0, m_upd});
    check({tag, " range R8"}, {8'h0, r1_a, r0_a, r1_b, r0_b}, {8'h0, m_rng, m_rng});
  endtask

  // Called at a negative edge; returns at the next negative edge.
  task automatic do_op(input logic w, input logic r, input logic wd,
                       input logic [3:0] a, input logic [15:0] d);
    logic dac;
    int   c;
    addr = a; wdata = d; wr = w; rd = r; word = wd;
    #1;
    if (r) begin
      check("rdata w16 R2 R7 R8", rdata_a, exp_rdata(a, wd, 16));
      check("rdata w12 R2 R6 R7", rdata_b, exp_rdata(a, wd, 12));
    end
    dac = (a[3:2] == 2'b01);
    c = a[1];
    m_upd = '0;
    if (w) begin
      if (dac) begin
        if (wd) begin m_lo[c] = d[7:0]; m_hi[c] = d[15:8]; end
        else if (a[0]) m_hi[c] = d[7:0];
        else m_lo[c] = d[7:0];
        if (!sim_mode && (wd || a[0])) begin
          m_upd[c] = 1'b1;
          m_lat16[c] = exp_code(m_hi[c], m_lo[c], 16);
          m_lat12[c] = exp_code(m_hi[c], m_lo[c], 12);
        end
      end
      if (a[3:1] == 3'b101 && (wd || !a[0])) m_rng = d[7:4];
    end else if (r && dac && sim_mode) begin
      m_upd = 2'b11;
      for (int n = 0; n < 2; n++) begin
        m_lat16[n] = exp_code(m_hi[n], m_lo[n], 16);
        m_lat12[n] = exp_code(m_hi[n], m_lo[n], 12);
      end
    end
    @(negedge clk);
    wr = 0; rd = 0; word = 0;
    check_outputs("op");
  endtask

  task automatic apply_reset(input logic s);
    rst_n = 0; sim_mode = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    check_outputs("reset R1");
  endtask

  task automatic random_ops(input int count);
    for (int i = 0; i < count; i++) begin
      logic [3:0] a;
      int   pick;
      logic w, r;
      pick = $urandom % 8;
      case (pick)
        0, 1, 2, 3: a = 4'h4 + 4'(pick);
        4: a = 4'hA;
        5: a = 4'hB;
        6: a = 4'($urandom);
        default: a = 4'h4 + 4'($urandom % 4);
      endcase
      w = 1'($urandom);
      r = ($urandom % 5 == 0) ? 1'b1 : !w;
      do_op(w, r, 1'($urandom % 3 == 0), a, 16'($urandom));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // per-channel mode, directed
    apply_reset(1'b0);
    do_op(0, 1, 0, 4'hA, 16'h0);                // R1 range readback
    do_op(1, 0, 0, 4'h4, 16'h00A7);             // R4 low byte only, no update
    do_op(1, 0, 0, 4'h5, 16'h003C);             // R3 high byte updates ch0, R6 nibble drop
    do_op(0, 1, 0, 4'h4, 16'h0);                // R6 low nibble reads back zero at 12 bits
    do_op(1, 0, 1, 4'h7, 16'hBEEF);             // R7 word write, bit0 ignored, ch1 update
    do_op(0, 1, 1, 4'h6, 16'h0);                // R7 word read
    do_op(1, 0, 0, 4'hA, 16'h00D0);             // R8 ranges ch0=1 ch1=3
    do_op(1, 0, 0, 4'hB, 16'h0000);             // R8 byte at 0x0B ignored
    do_op(1, 0, 0, 4'h2, 16'hFFFF);             // R8 stray offset ignored
    random_ops(600);
    // simultaneous mode
    apply_reset(1'b1);
    do_op(1, 0, 1, 4'h4, 16'h1234);             // R5 write does not load
    do_op(1, 0, 1, 4'h6, 16'h5678);
    do_op(1, 1, 0, 4'h5, 16'h0099);             // R9 write wins, no transfer
    do_op(0, 1, 0, 4'hA, 16'h0);                // R5 read outside DAC offsets: nothing
    do_op(0, 1, 0, 4'h7, 16'h0);                // R5 transfer both together
    do_op(0, 0, 0, 4'h0, 16'h0);                // R10 strobes drop, codes hold
    random_ops(600);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule